// File: doc/BRIEF.md
# Hybrid Pointer/Vector Coherence Directory Set

This block holds one set of a coherence directory. The set has `NWAYS` ways. The low `NVEC` ways are vector ways, and each of them keeps a full bit vector of sharing cores. The remaining ways are pointer ways, and each of them names one core. Requests arrive one per cycle. Each request carries a line tag, a core number and an operation: lookup, add a sharer, or remove a sharer. One cycle later the block returns the line's sharers after the operation has been applied.

A line starts in a pointer way. When a second core must be recorded for that line, the line moves into a free vector way. If no vector way is free, the least recently used vector way is chosen as the victim, and the two entries trade places:

- The requesting line takes the vector way.
- The victim line drops into the pointer way.
- If the victim has fewer than `THRESH` sharers, it keeps only its lowest-numbered core, and the other cores are reported for invalidation.
- Otherwise the victim is marked as broadcast, and from then on it reports every core as a possible holder.

The whole exchange completes on a single clock edge.

Top module: `dir_hybrid_set`

## Requirements
- R1: Every request (`req_valid`=1) produces exactly one response (`rsp_valid`=1) one cycle later. Operation codes are 0 lookup, 1 add, 2 remove, and 3 acts as lookup. After reset every lookup misses, with `rsp_hit`=0 and `rsp_sharers`=0.
- R2: An add that misses takes the lowest free pointer way. The response has `rsp_hit`=0 and `rsp_vec`=0, and `rsp_sharers` is one-hot on the requesting core.
- R3: An add of a second core to a pointer-way line, while a vector way is free, moves the line into that vector way. The response has `rsp_vec`=1 and both cores set.
- R4: With no free vector way, the least recently used vector way is the victim. Any hit in a vector way or fill of a vector way counts as a use. The requesting line takes the victim's vector way, and the victim line takes the pointer way. `inv_mask` and `bcast_mark` are non-zero only in this case.
- R5: A victim with fewer than `THRESH` sharers keeps its lowest-numbered core. All of its other cores appear in `inv_mask`.
- R6: A victim with `THRESH` or more sharers raises `bcast_mark`. Later lookups of that line return `rsp_bcast`=1 with all `rsp_sharers` bits set.
- R7: A request in the cycle right after a swap sees the state after the swap is complete.
- R8: Removing a core from a vector-way line clears that core's bit. The line stays in its vector way even when one sharer remains, and it is freed when none remain.
- R9: Removing the owning core from a pointer-way line frees that way. Removing any other core, or any remove on a broadcast line, changes nothing.
- R10: Adding the core that already owns a pointer-way line changes nothing.
- R11: An add that misses while no pointer way is free raises `rsp_full` with `rsp_hit`=0, and the line is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 lookup, 1 add, 2 remove |
| req_tag | input | TAG_W | Line tag |
| req_core | input | $clog2(NCORES) | Requesting core |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag was present before the operation |
| rsp_vec | output | 1 | Line sits in a vector way after the operation |
| rsp_bcast | output | 1 | Line is marked broadcast |
| rsp_full | output | 1 | Add miss found no free pointer way |
| rsp_sharers | output | NCORES | Sharers of the line after the operation |
| inv_mask | output | NCORES | Cores to invalidate after rounding a victim down |
| bcast_mark | output | 1 | Victim was converted to a broadcast pointer |

## Verification
Directed sequences cover several cases:

- A single core per line exercises plain pointer allocation.
- A second core arriving while a vector way is free shows the move without any swap.
- Two lines sharing the full pool of vector ways, with a lookup in between, force a chosen LRU victim.
- One victim with three sharers and one with two sharers separate the broadcast outcome from the rounding outcome, including which core is kept.

Remove sequences compare the vector-way and pointer-way paths and show that a broadcast line ignores removes. A final set of fills shows the pointer pool running out.

// File: rtl/dir_hybrid_set.sv
module dir_hybrid_set #(
  parameter int NCORES = 8,
  parameter int NWAYS  = 6,
  parameter int NVEC   = 2,
  parameter int THRESH = 3,
  parameter int TAG_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [TAG_W-1:0]          req_tag,
  input  logic [$clog2(NCORES)-1:0] req_core,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_vec,
  output logic                      rsp_bcast,
  output logic                      rsp_full,
  output logic [NCORES-1:0]         rsp_sharers,
  output logic [NCORES-1:0]         inv_mask,
  output logic                      bcast_mark
);
  localparam int CW = $clog2(NCORES);
  localparam int WW = $clog2(NWAYS);
  localparam int AW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic              v_q   [NWAYS];
  logic [TAG_W-1:0]  tag_q [NWAYS];
  logic [CW-1:0]     own_q [NWAYS];
  logic              bc_q  [NWAYS];
  logic [NCORES-1:0] shv_q [NWAYS];
  logic [AW-1:0]     age_q [NVEC];

  logic              v_n   [NWAYS];
  logic [TAG_W-1:0]  tag_n [NWAYS];
  logic [CW-1:0]     own_n [NWAYS];
  logic              bc_n  [NWAYS];
  logic [NCORES-1:0] shv_n [NWAYS];
  logic [AW-1:0]     age_n [NVEC];

  logic hit, fv_ok, fp_ok, touch;
  logic [WW-1:0] hw, fv_way, fp_way, lru_way, tw;
  logic [AW-1:0] tage;
  logic [NCORES-1:0] sv, r_sh, r_inv, req_oh;
  logic [CW-1:0] low;
  logic r_vec, r_bc, r_full, r_bmark;

  assign req_oh = NCORES'(1) << req_core;

  always_comb begin
    hit = 1'b0; hw = '0;
    fv_ok = 1'b0; fv_way = '0;
    fp_ok = 1'b0; fp_way = '0;
    lru_way = '0;
    for (int i = 0; i < NWAYS; i++) begin
      if (v_q[i] && tag_q[i] == req_tag && !hit) begin hit = 1'b1; hw = WW'(i); end
      if (!v_q[i] && i < NVEC && !fv_ok) begin fv_ok = 1'b1; fv_way = WW'(i); end
      if (!v_q[i] && i >= NVEC && !fp_ok) begin fp_ok = 1'b1; fp_way = WW'(i); end
    end
    for (int i = 0; i < NVEC; i++)
      if (age_q[i] == AW'(NVEC-1)) lru_way = WW'(i);

    v_n = v_q; tag_n = tag_q; own_n = own_q; bc_n = bc_q; shv_n = shv_q; age_n = age_q;
    touch = 1'b0; tw = '0;
    r_inv = '0; r_bmark = 1'b0; r_full = 1'b0;
    sv = shv_q[lru_way]; low = '0;
    for (int c = NCORES-1; c >= 0; c--) if (sv[c]) low = CW'(c);

    if (req_valid) begin
      if (req_op == 2'd1) begin
        if (!hit) begin
          if (fp_ok) begin
            v_n[fp_way] = 1'b1; tag_n[fp_way] = req_tag;
            own_n[fp_way] = req_core; bc_n[fp_way] = 1'b0;
          end else r_full = 1'b1;
        end else if (hw < WW'(NVEC)) begin
          shv_n[hw] = shv_q[hw] | req_oh; touch = 1'b1; tw = hw;
        end else if (!bc_q[hw] && own_q[hw] != req_core) begin
          tw = fv_ok ? fv_way : lru_way; touch = 1'b1;
          if (fv_ok) v_n[hw] = 1'b0;
          else begin
            tag_n[hw] = tag_q[lru_way]; own_n[hw] = low;
            if ($countones(sv) >= THRESH) begin
              bc_n[hw] = 1'b1; r_bmark = 1'b1;
            end else begin
              bc_n[hw] = 1'b0; r_inv = sv & ~(NCORES'(1) << low);
            end
          end
          v_n[tw] = 1'b1; tag_n[tw] = req_tag;
          shv_n[tw] = (NCORES'(1) << own_q[hw]) | req_oh;
        end
      end else if (req_op == 2'd2 && hit) begin
        if (hw < WW'(NVEC)) begin
          shv_n[hw] = shv_q[hw] & ~req_oh;
          if ((shv_q[hw] & ~req_oh) == '0) v_n[hw] = 1'b0;
          else begin touch = 1'b1; tw = hw; end
        end else if (!bc_q[hw] && own_q[hw] == req_core) v_n[hw] = 1'b0;
      end else if (hit && hw < WW'(NVEC)) begin
        touch = 1'b1; tw = hw;
      end
    end

    tage = '0;
    for (int i = 0; i < NVEC; i++) if (WW'(i) == tw) tage = age_q[i];
    if (touch)
      for (int i = 0; i < NVEC; i++)
        if (WW'(i) == tw) age_n[i] = '0;
        else if (age_q[i] < tage) age_n[i] = age_q[i] + AW'(1);

    r_sh = '0; r_vec = 1'b0; r_bc = 1'b0;
    for (int i = 0; i < NWAYS; i++)
      if (v_n[i] && tag_n[i] == req_tag) begin
        if (i < NVEC) begin r_sh = shv_n[i]; r_vec = 1'b1; end
        else if (bc_n[i]) begin r_sh = '1; r_bc = 1'b1; end
        else r_sh = NCORES'(1) << own_n[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWAYS; i++) begin
        v_q[i] <= 1'b0; tag_q[i] <= '0; own_q[i] <= '0; bc_q[i] <= 1'b0; shv_q[i] <= '0;
      end
      for (int i = 0; i < NVEC; i++) age_q[i] <= AW'(i);
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_vec <= 1'b0; rsp_bcast <= 1'b0;
      rsp_full <= 1'b0; rsp_sharers <= '0; inv_mask <= '0; bcast_mark <= 1'b0;
    end else begin
      v_q <= v_n; tag_q <= tag_n; own_q <= own_n; bc_q <= bc_n; shv_q <= shv_n; age_q <= age_n;
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid & hit;
      rsp_vec     <= req_valid & r_vec;
      rsp_bcast   <= req_valid & r_bc;
      rsp_full    <= req_valid & r_full;
      rsp_sharers <= req_valid ? r_sh : '0;
      inv_mask    <= r_inv;
      bcast_mark  <= r_bmark;
    end
  end
endmodule

// File: rtl/dir_hybrid_set_chk.sv
module dir_hybrid_set_chk #(
  parameter int NCORES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_vec,
  input logic              rsp_bcast,
  input logic              rsp_full,
  input logic [NCORES-1:0] rsp_sharers,
  input logic [NCORES-1:0] inv_mask,
  input logic              bcast_mark
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_alloc_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_full && $past(req_op) == 2'd1) |-> ($countones(rsp_sharers) == 1 && !rsp_vec));
  assert_swap_only_on_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_mask != '0 || bcast_mark) |-> ($past(req_valid) && $past(req_op) == 2'd1 && rsp_hit && rsp_vec));
  assert_round_or_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_mask != '0 && bcast_mark));
  assert_bcast_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bcast |-> (&rsp_sharers && !rsp_vec));
  assert_full_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> (!rsp_hit && rsp_sharers == '0));
endmodule

bind dir_hybrid_set dir_hybrid_set_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_vec(rsp_vec), .rsp_bcast(rsp_bcast),
  .rsp_full(rsp_full), .rsp_sharers(rsp_sharers), .inv_mask(inv_mask), .bcast_mark(bcast_mark)
);

// File: tb/dir_hybrid_set_test.sv
`timescale 1ns/1ps
module dir_hybrid_set_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [11:0] req_tag = '0;
  logic [2:0] req_core = '0;
  logic rsp_valid, rsp_hit, rsp_vec, rsp_bcast, rsp_full, bcast_mark;
  logic [7:0] rsp_sharers, inv_mask;
  int tests = 0, fails = 0;

  localparam logic [1:0] LK = 2'd0, ADD = 2'd1, RM = 2'd2;
  localparam logic [11:0] TA = 12'h0A0, TB = 12'h0B0, TC = 12'h0C0, TD = 12'h0D0,
                          TE = 12'h0E0, TF = 12'h0F0, TG = 12'h100, TI = 12'h110;

  always #2 clk = ~clk;

  dir_hybrid_set uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_tag(req_tag),
    .req_core(req_core), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_vec(rsp_vec),
    .rsp_bcast(rsp_bcast), .rsp_full(rsp_full), .rsp_sharers(rsp_sharers),
    .inv_mask(inv_mask), .bcast_mark(bcast_mark)
  );

  task automatic req(input logic [1:0] op, input logic [11:0] t, input logic [2:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_tag = t; req_core = c;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic h, input logic vec, input logic bc,
                     input logic full, input logic [7:0] sh, input logic [7:0] inv, input logic bm);
    tests++;
    if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_vec !== vec || rsp_bcast !== bc ||
        rsp_full !== full || rsp_sharers !== sh || inv_mask !== inv || bcast_mark !== bm) begin
      fails++;
      $display("FAIL %s: got v%b h%b vec%b bc%b full%b sh%h inv%h bm%b, exp v1 h%b vec%b bc%b full%b sh%h inv%h bm%b",
               r, rsp_valid, rsp_hit, rsp_vec, rsp_bcast, rsp_full, rsp_sharers, inv_mask, bcast_mark,
               h, vec, bc, full, sh, inv, bm);
    end
  endtask

  task automatic t_reset;
    req(LK, TA, 3'd0); chk("R1 reset lookup misses", 0, 0, 0, 0, 8'h00, 8'h00, 0);
  endtask

  task automatic t_alloc_and_move;
    req(ADD, TA, 3'd1); chk("R2 miss alloc pointer", 0, 0, 0, 0, 8'h02, 8'h00, 0);
    req(ADD, TA, 3'd3); chk("R3 move to free vector", 1, 1, 0, 0, 8'h0A, 8'h00, 0);
    req(ADD, TB, 3'd2); chk("R2 second line alloc", 0, 0, 0, 0, 8'h04, 8'h00, 0);
    req(ADD, TB, 3'd5); chk("R3 second vector fill", 1, 1, 0, 0, 8'h24, 8'h00, 0);
    req(ADD, TA, 3'd6); chk("R4 vector add sharer", 1, 1, 0, 0, 8'h4A, 8'h00, 0);
  endtask

  task automatic t_bcast_swap;
    req(LK, TB, 3'd0); chk("R4 touch B", 1, 1, 0, 0, 8'h24, 8'h00, 0);
    req(ADD, TC, 3'd0); chk("R2 alloc C", 0, 0, 0, 0, 8'h01, 8'h00, 0);
    req(ADD, TC, 3'd4); chk("R6 swap victim A to broadcast", 1, 1, 0, 0, 8'h11, 8'h00, 1);
    req(LK, TA, 3'd0); chk("R7 R6 A broadcast right after swap", 1, 0, 1, 0, 8'hFF, 8'h00, 0);
    req(LK, TC, 3'd0); chk("R4 C in vector", 1, 1, 0, 0, 8'h11, 8'h00, 0);
  endtask

  task automatic t_round_swap;
    req(ADD, TD, 3'd7); chk("R2 alloc D", 0, 0, 0, 0, 8'h80, 8'h00, 0);
    req(ADD, TD, 3'd1); chk("R5 round victim B", 1, 1, 0, 0, 8'h82, 8'h20, 0);
    req(LK, TB, 3'd0); chk("R5 B keeps lowest core", 1, 0, 0, 0, 8'h04, 8'h00, 0);
  endtask

  task automatic t_remove;
    req(RM, TC, 3'd4); chk("R8 one sharer left stays vector", 1, 1, 0, 0, 8'h01, 8'h00, 0);
    req(RM, TC, 3'd0); chk("R8 last sharer removed", 1, 0, 0, 0, 8'h00, 8'h00, 0);
    req(LK, TC, 3'd0); chk("R8 freed vector line misses", 0, 0, 0, 0, 8'h00, 8'h00, 0);
    req(RM, TB, 3'd2); chk("R9 owner removed", 1, 0, 0, 0, 8'h00, 8'h00, 0);
    req(LK, TB, 3'd0); chk("R9 freed pointer misses", 0, 0, 0, 0, 8'h00, 8'h00, 0);
    req(RM, TA, 3'd5); chk("R9 broadcast ignores remove", 1, 0, 1, 0, 8'hFF, 8'h00, 0);
    req(ADD, TE, 3'd3); chk("R2 alloc E", 0, 0, 0, 0, 8'h08, 8'h00, 0);
    req(RM, TE, 3'd6); chk("R9 non-owner remove ignored", 1, 0, 0, 0, 8'h08, 8'h00, 0);
    req(ADD, TE, 3'd3); chk("R10 same owner add no change", 1, 0, 0, 0, 8'h08, 8'h00, 0);
  endtask

  task automatic t_full;
    req(ADD, TF, 3'd2); chk("R2 alloc F", 0, 0, 0, 0, 8'h04, 8'h00, 0);
    req(ADD, TG, 3'd4); chk("R2 alloc G", 0, 0, 0, 0, 8'h10, 8'h00, 0);
    req(ADD, TI, 3'd0); chk("R11 no free pointer", 0, 0, 0, 1, 8'h00, 8'h00, 0);
    req(LK, TI, 3'd0); chk("R11 line not stored", 0, 0, 0, 0, 8'h00, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_alloc_and_move();
    t_bcast_swap();
    t_round_swap();
    t_remove();
    t_full();
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle response: got %b exp 0", rsp_valid);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #40000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule